// File: doc/BRIEF.md
# Halfword-to-Word Burst Writer

This block accepts a stream of 16-bit samples over a valid/ready handshake and stores them to memory as a master on the write side of an AXI4 bus with a 32-bit data path. A stream begins with a one-cycle `start` pulse that carries its byte address. The stream closes on the sample flagged `in_last`. Pairs of samples are merged into one 32-bit beat; the sample at the lower address goes to bits 15:0. Beats wait in a small internal queue. A burst goes out as soon as `BURST_LEN` beats are queued. Once the closing sample has arrived, whatever is left is drained in a shorter burst.

Every beat is a full 4-byte transfer. A start address that is a multiple of two but not of four is handled with byte strobes on the first beat. A stream that ends on an unpaired sample is handled with byte strobes on the last beat. Only one burst is outstanding at a time. The address for the next burst moves forward by the number of bytes just written. A write response other than OKAY sets a sticky error flag. The flag stays set until `err_clr` is pulsed.

Top module: `hbw_burst_writer`

## Requirements
- R1: With a 4-byte-aligned start, sample 2k goes to `wdata[15:0]` and sample 2k+1 goes to `wdata[31:16]` of one beat, with `wstrb` = 4'b1111.
- R2: Every address request carries `awsize` = 3'd2 (4 bytes per beat) and `awburst` = 2'b01 (incrementing).
- R3: When `start_addr[1:0]` = 2'b10, `awaddr` of the first burst is `start_addr` rounded down to a multiple of 4. The first beat carries sample 0 in `wdata[31:16]` with `wstrb` = 4'b1100, and bytes below `start_addr` are never written.
- R4: A stream that ends on an unpaired sample sends it in `wdata[15:0]` of the final beat with `wstrb` = 4'b0011, and the bytes above it are not written.
- R5: A burst of exactly `BURST_LEN` beats (`awlen` = `BURST_LEN`-1) is requested whenever at least that many beats are queued.
- R6: After the closing sample is queued, any remainder smaller than `BURST_LEN` goes out as one burst with `awlen` = beats-1, and the beat built from the closing sample always ends its burst.
- R7: `awvalid` and its fields hold until `awready`. Each W beat holds until `wready`. `wlast` is high exactly on the beat whose index within the burst equals `awlen`.
- R8: Each burst's `awaddr` equals the previous one plus 4 × its beat count. No new address request is made before the previous burst's write response has been accepted.
- R9: A response with `bresp` other than 2'b00 sets `err_flag`. The flag stays set until a cycle with `err_clr` high, after which it reads 0.
- R10: `in_ready` is low while the beat queue is full. Every accepted sample is written exactly once, at its own address.
- R11: After reset, `idle` is 1, `in_ready`, `awvalid`, `wvalid` and `err_flag` are 0, and `start` is ignored unless `idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a stream at `start_addr` (taken only while idle) |
| start_addr | input | ADDR_W | Byte address of the first sample (even) |
| idle | output | 1 | No stream open, queue empty, no burst in progress |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample accepted when high together with `in_valid` |
| in_data | input | 16 | Sample |
| in_last | input | 1 | Marks the closing sample of the stream |
| awaddr | output | ADDR_W | Burst start address |
| awlen | output | 8 | Beats minus one |
| awsize | output | 3 | Bytes per beat code |
| awburst | output | 2 | Burst type |
| awvalid | output | 1 | Address request valid |
| awready | input | 1 | Address request accepted |
| wdata | output | 32 | Write data |
| wstrb | output | 4 | Byte lane enables |
| wlast | output | 1 | Final beat of the burst |
| wvalid | output | 1 | Write beat valid |
| wready | input | 1 | Write beat accepted |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response accepted |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky flag for a failed write response |

## Verification
The assertions assume a start address with bit 0 clear, and they flag an odd one. They also assume that the caller gives no more than 4 KB per burst run, so that no burst wraps past a page. The stimulus keeps to both: every stream starts on an even address well inside a 256-byte window. The subordinate model holds `bvalid` until it is accepted and only answers bursts whose closing beat it has seen. That matches the response ordering the controller waits on. Back-pressure is produced by withholding `awready` for a long stretch and by stalling `wready` in a repeating pattern. Together these fill the queue and hold every handshake open for several cycles.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

  typedef struct packed {
    logic        last;
    logic [3:0]  strb;
    logic [31:0] data;
  } beat_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } wstate_e;

  localparam logic [2:0] SIZE_WORD  = 3'd2;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;

endpackage

// File: rtl/hbw_packer.sv
module hbw_packer
  import hbw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        load_hi,
  input  logic        take,
  input  logic [15:0] take_data,
  input  logic        take_last,
  output logic        push,
  output beat_t       push_beat
);

  logic        phase_q, phase_d;
  logic        have_q, have_d;
  logic [15:0] lo_q, lo_d;

  always_comb begin
    phase_d   = phase_q;
    have_d    = have_q;
    lo_d      = lo_q;
    push      = 1'b0;
    push_beat = '0;
    if (load) begin
      phase_d = load_hi;
      have_d  = 1'b0;
    end else if (take) begin
      if (!phase_q) begin
        if (take_last) begin
          push           = 1'b1;
          push_beat.last = 1'b1;
          push_beat.strb = 4'b0011;
          push_beat.data = {16'h0000, take_data};
        end else begin
          lo_d    = take_data;
          have_d  = 1'b1;
          phase_d = 1'b1;
        end
      end else begin
        push           = 1'b1;
        push_beat.last = take_last;
        push_beat.strb = {2'b11, {2{have_q}}};
        push_beat.data = {take_data, (have_q ? lo_q : 16'h0000)};
        phase_d        = 1'b0;
        have_d         = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      have_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      have_q  <= have_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) lo_q <= lo_d;
  end

  // A lower-half-only beat can only come from the closing sample.
  assert_lone_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push && (push_beat.strb == 4'b0011) |-> push_beat.last);

endmodule

// File: rtl/hbw_beat_fifo.sv
module hbw_beat_fifo
  import hbw_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  beat_t            push_beat,
  input  logic             pop,
  output beat_t            head,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             empty
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  beat_t            store_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store_q[wr_q] <= push_beat;
  end

  assign head  = store_q[rd_q];
  assign cnt   = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/hbw_burst_writer.sv
module hbw_burst_writer
  import hbw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BURST_LEN = 16,
  parameter int DEPTH     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              idle,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_data,
  input  logic              in_last,
  output logic [ADDR_W-1:0] awaddr,
  output logic [7:0]        awlen,
  output logic [2:0]        awsize,
  output logic [1:0]        awburst,
  output logic              awvalid,
  input  logic              awready,
  output logic [31:0]       wdata,
  output logic [3:0]        wstrb,
  output logic              wlast,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  input  logic              err_clr,
  output logic              err_flag
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_BURST = CNT_W'(BURST_LEN);
  localparam logic [7:0]       FULL_LEN   = 8'(BURST_LEN - 1);

  wstate_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        len_q, len_d, beat_q, beat_d;
  logic              active_q, active_d;
  logic              seen_q, seen_d;
  logic              err_q, err_d;

  logic              start_ok, take, push, pop, full, empty, resp_hs;
  beat_t             push_beat, head;
  logic [CNT_W-1:0]  cnt;

  assign start_ok = start && idle;
  assign take     = in_valid && in_ready;
  assign pop      = wvalid && wready;
  assign resp_hs  = bvalid && bready;

  hbw_packer u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .load_hi   (start_addr[1]),
    .take      (take),
    .take_data (in_data),
    .take_last (in_last),
    .push      (push),
    .push_beat (push_beat)
  );

  hbw_beat_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_beat (push_beat),
    .pop       (pop),
    .head      (head),
    .cnt       (cnt),
    .full      (full),
    .empty     (empty)
  );

  always_comb begin
    st_d     = st_q;
    addr_d   = addr_q;
    len_d    = len_q;
    beat_d   = beat_q;
    active_d = active_q;
    seen_d   = seen_q;
    err_d    = (err_q && !err_clr) || (resp_hs && (bresp != RESP_OKAY));
    if (start_ok) begin
      addr_d   = {start_addr[ADDR_W-1:2], 2'b00};
      active_d = 1'b1;
      seen_d   = 1'b0;
    end else begin
      if (take && in_last) active_d = 1'b0;
      if (push && push_beat.last) seen_d = 1'b1;
    end
    case (st_q)
      ST_IDLE: begin
        beat_d = '0;
        if (cnt >= FULL_BURST) begin
          len_d = FULL_LEN;
          st_d  = ST_ADDR;
        end else if (seen_q && !empty) begin
          len_d = 8'(cnt - CNT_W'(1));
          st_d  = ST_ADDR;
        end
      end
      ST_ADDR: if (awready) st_d = ST_DATA;
      ST_DATA: begin
        if (pop) begin
          if (beat_q == len_q) st_d = ST_RESP;
          else beat_d = beat_q + 8'd1;
        end
      end
      default: begin
        if (bvalid) begin
          st_d   = ST_IDLE;
          addr_d = addr_q + ADDR_W'({len_q, 2'b00}) + ADDR_W'(4);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      len_q    <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
      seen_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      addr_q   <= addr_d;
      len_q    <= len_d;
      beat_q   <= beat_d;
      active_q <= active_d;
      seen_q   <= seen_d;
      err_q    <= err_d;
    end
  end

  assign idle     = !active_q && empty && (st_q == ST_IDLE);
  assign in_ready = active_q && !full;
  assign awvalid  = (st_q == ST_ADDR);
  assign awaddr   = addr_q;
  assign awlen    = len_q;
  assign awsize   = SIZE_WORD;
  assign awburst  = BURST_INCR;
  assign wvalid   = (st_q == ST_DATA);
  assign wdata    = head.data;
  assign wstrb    = head.strb;
  assign wlast    = wvalid && (beat_q == len_q);
  assign bready   = (st_q == ST_RESP);
  assign err_flag = err_q;

  assert_aw_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));
  assert_w_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wstrb) && $stable(wlast));
  assert_tail_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop && head.last |-> wlast);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);
  assert_even_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start && idle |-> !start_addr[0]);
  assert_resp_before_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bready && bvalid |=> !awvalid);

endmodule

// File: tb/hbw_burst_writer_test.sv
module hbw_burst_writer_test;

  localparam int ADDR_W = 16;
  localparam int BL     = 4;
  localparam int DEP    = 8;

  logic clk, rst_n;
  logic start; logic [ADDR_W-1:0] start_addr; logic idle;
  logic in_valid, in_ready, in_last; logic [15:0] in_data;
  logic [ADDR_W-1:0] awaddr; logic [7:0] awlen; logic [2:0] awsize; logic [1:0] awburst;
  logic awvalid, awready;
  logic [31:0] wdata; logic [3:0] wstrb; logic wlast, wvalid, wready;
  logic [1:0] bresp; logic bvalid, bready;
  logic err_clr, err_flag;

  hbw_burst_writer #(.ADDR_W(ADDR_W), .BURST_LEN(BL), .DEPTH(DEP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .idle(idle),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
    .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .err_clr(err_clr), .err_flag(err_flag));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;

  // subordinate model state
  logic [7:0] mem [256];
  bit         wr  [256];
  int aw_addr_log [16];
  int aw_len_log  [16];
  logic [3:0] strb_log [64];
  int aw_n, w_n, w_burst, cur_beat, b_pending, bursts_done;
  int order_err, proto_err, size_err, cyc;
  bit aw_hold, stall_mode, err_next;
  int max_stall;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] hw(input int base, input int i);
    return 16'((base << 8) ^ (i * 16'h0111) ^ 16'h3C5A);
  endfunction

  task automatic clear_logs();
    for (int a = 0; a < 256; a++) begin mem[a] = 8'h00; wr[a] = 0; end
    aw_n = 0; w_n = 0; w_burst = 0; cur_beat = 0; bursts_done = 0;
    order_err = 0; proto_err = 0; size_err = 0; max_stall = 0;
  endtask

  initial begin
    awready = 0; wready = 0; bvalid = 0; bresp = 2'b00; b_pending = 0; cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      awready = !aw_hold;
      wready  = !stall_mode || (cyc % 3 != 0);
      if (b_pending > 0) begin bvalid = 1; bresp = err_next ? 2'b10 : 2'b00; end
      else begin bvalid = 0; bresp = 2'b00; end
      if (awvalid && awready) begin
        if (bursts_done != aw_n) order_err++;
        if (awsize != 3'd2 || awburst != 2'b01) size_err++;
        aw_addr_log[aw_n] = int'(awaddr);
        aw_len_log[aw_n]  = int'(awlen);
        aw_n++;
      end
      if (wvalid && wready) begin
        if (w_burst >= aw_n) proto_err++;
        else begin
          for (int b = 0; b < 4; b++) begin
            if (wstrb[b]) begin
              mem[(aw_addr_log[w_burst] + 4*cur_beat + b) & 255] = wdata[8*b +: 8];
              wr[(aw_addr_log[w_burst] + 4*cur_beat + b) & 255]  = 1;
            end
          end
          if (w_n < 64) strb_log[w_n] = wstrb;
          w_n++;
          if (wlast != (cur_beat == aw_len_log[w_burst])) proto_err++;
          if (wlast) begin cur_beat = 0; w_burst++; b_pending++; end
          else cur_beat++;
        end
      end
      if (bvalid && bready) begin b_pending--; bursts_done++; err_next = 0; end
    end
  end

  task automatic send_stream(input int base, input int n, input bit gaps);
    @(negedge clk); start_addr = ADDR_W'(base); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = hw(base, i); in_last = (i == n-1);
      #1;
      begin
        int stall = 0;
        while (!in_ready) begin stall++; @(negedge clk); #1; end
        if (stall > max_stall) max_stall = stall;
      end
      @(negedge clk); in_valid = 0; in_last = 0;
      if (gaps && (i % 3 == 1)) @(negedge clk);
    end
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    @(negedge clk); #1;
    while (!(idle && b_pending == 0 && aw_n == bursts_done) && t < 3000) begin
      @(negedge clk); #1; t++;
    end
    chk(t < 3000, req, "stream completes", t, 0);
  endtask

  task automatic verify(input int base, input int n, input string req);
    int mism = 0, extra = 0;
    for (int i = 0; i < n; i++) begin
      if (!wr[base+2*i] || !wr[base+2*i+1] || {mem[base+2*i+1], mem[base+2*i]} != hw(base, i))
        mism++;
    end
    chk(mism == 0, req, "samples written once in place", mism, 0);
    for (int a = base & ~3; a < base; a++) extra += int'(wr[a]);
    for (int a = base + 2*n; (a % 4) != 0; a++) extra += int'(wr[a]);
    chk(extra == 0, req, "lanes outside stream untouched", extra, 0);
    chk(order_err == 0 && proto_err == 0, "R7", "wlast position and B ordering", proto_err + order_err, 0);
    chk(size_err == 0, "R2", "awsize/awburst full width incr", size_err, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; start = 0; start_addr = '0; in_valid = 0; in_data = '0; in_last = 0;
    err_clr = 0; aw_hold = 0; stall_mode = 0; err_next = 0;
    clear_logs();
    repeat (3) @(negedge clk);
    chk(idle == 1'b1, "R11", "idle in reset", idle, 1);
    chk(in_ready == 1'b0 && awvalid == 1'b0 && wvalid == 1'b0, "R11", "outputs quiet in reset",
        {in_ready, awvalid, wvalid}, 0);
    chk(err_flag == 1'b0, "R11", "err_flag in reset", err_flag, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_aligned_full();
    clear_logs();
    send_stream(16'h10, 8, 0);
    wait_done("R5");
    chk(aw_n == 1 && aw_len_log[0] == BL-1, "R5", "one full burst awlen", aw_len_log[0], BL-1);
    chk(aw_addr_log[0] == 16'h10, "R1", "awaddr aligned", aw_addr_log[0], 16'h10);
    chk(strb_log[0] == 4'hF && strb_log[3] == 4'hF, "R1", "full strobes", {strb_log[0], strb_log[3]}, 8'hFF);
    verify(16'h10, 8, "R1");
  endtask

  task automatic t_half_start();
    clear_logs();
    send_stream(16'h42, 5, 1);
    wait_done("R3");
    chk(aw_n == 1 && aw_addr_log[0] == 16'h40, "R3", "awaddr rounded down", aw_addr_log[0], 16'h40);
    chk(aw_len_log[0] == 2, "R6", "drain burst awlen", aw_len_log[0], 2);
    chk(strb_log[0] == 4'b1100, "R3", "first beat strobes", strb_log[0], 4'b1100);
    verify(16'h42, 5, "R3");
  endtask

  task automatic t_odd_end();
    clear_logs();
    send_stream(16'h80, 3, 0);
    wait_done("R4");
    chk(aw_n == 1 && aw_len_log[0] == 1, "R6", "two-beat drain awlen", aw_len_log[0], 1);
    chk(strb_log[1] == 4'b0011, "R4", "last beat strobes", strb_log[1], 4'b0011);
    verify(16'h80, 3, "R4");
  endtask

  task automatic t_backpressure();
    clear_logs();
    aw_hold = 1; stall_mode = 1;
    fork
      send_stream(16'hA0, 20, 0);
      begin
        repeat (30) @(negedge clk);
        start_addr = 16'h0000; start = 1;
        @(negedge clk); start = 0; start_addr = 16'h00A0;
        repeat (30) @(negedge clk);
        aw_hold = 0;
      end
    join
    wait_done("R10");
    stall_mode = 0;
    chk(max_stall >= 10, "R10", "in_ready low while queue full", max_stall, 10);
    chk(aw_n == 3, "R6", "burst count 4+4+2", aw_n, 3);
    chk(aw_addr_log[0] == 16'hA0 && aw_addr_log[1] == 16'hB0 && aw_addr_log[2] == 16'hC0,
        "R8", "addresses advance by 4*beats", aw_addr_log[2], 16'hC0);
    chk(aw_len_log[0] == 3 && aw_len_log[1] == 3 && aw_len_log[2] == 1, "R5", "lengths", aw_len_log[2], 1);
    chk(aw_addr_log[0] == 16'hA0, "R11", "start while busy ignored", aw_addr_log[0], 16'hA0);
    verify(16'hA0, 20, "R10");
  endtask

  task automatic t_error();
    clear_logs();
    err_next = 1;
    send_stream(16'h20, 2, 0);
    wait_done("R9");
    chk(err_flag == 1'b1, "R9", "error set on SLVERR", err_flag, 1);
    repeat (5) @(negedge clk);
    chk(err_flag == 1'b1, "R9", "error sticky", err_flag, 1);
    err_clr = 1; @(negedge clk); err_clr = 0; #1;
    chk(err_flag == 1'b0, "R9", "error cleared", err_flag, 0);
    verify(16'h20, 2, "R9");
    clear_logs();
    send_stream(16'h30, 4, 0);
    wait_done("R9");
    chk(err_flag == 1'b0, "R9", "OKAY leaves flag clear", err_flag, 0);
  endtask

  initial begin
    t_reset();
    t_aligned_full();
    t_half_start();
    t_odd_end();
    t_backpressure();
    t_error();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule